// File: doc/BRIEF.md
# Bank Ending-Address Accumulator

This block turns the sizes of up to four external memory banks, already found by probing, into the form a memory decoder uses. Each bank gets one byte of a 32-bit ending-address word. A populated bank's byte holds the cumulative top of memory in 4 MiB units, with bit 7 marking the byte as valid. A 16-bit configuration word collects one 4-bit geometry code per bank. The total installed memory is reported in bytes.

A start pulse loads the four raw size bytes into the ending-address word and latches the four configuration codes. The block then walks bank 0, 1, 2, 3, one bank per clock, and rewrites each byte in place. An empty bank (size zero) keeps a zero byte and does not move the running total. A populated bank gets the running total plus its size, limited to 0x7f. When the last bank is written, a one-cycle done pulse is raised and the byte count is updated from the highest valid bank.

Top module: `bank_end_accum`

## Requirements
- R1: While reset is held and after it is released, `end_addr_o` is 0, `cfg_word_o` is the parameter `CFG_INIT` (0xBBBB by default), `total_bytes_o` is 0, and `busy_o` and `done_o` are low.
- R2: A `start_i` sampled high while idle loads `size_i` unchanged into `end_addr_o` at that edge and raises `busy_o`. Banks 0 to 3 are then processed on the next four edges, one per edge. At the fourth of these edges `busy_o` falls and `done_o` goes high for exactly one cycle.
- R3: A bank whose size byte (bits 8N+7:8N of `size_i` for bank N) is 0x00 ends with a 0x00 byte, and the running total is unchanged for the banks above it.
- R4: A bank with a non-zero size byte ends with bit 7 set and bits 6:0 equal to the size plus the running total. When that sum, taken without truncation, exceeds 0x7f, bits 6:0 hold 0x7f.
- R5: The running total starts at 0 on each start and, after each populated bank, equals that bank's 7-bit value. Ending addresses therefore accumulate from bank 0 upward.
- R6: When bank N is processed, bits 4N+3:4N of `cfg_word_o` take bits 4N+3:4N of the latched `cfg_i`, and every other nibble keeps its value.
- R7: From the done edge on, `total_bytes_o` equals bits 6:0 of the highest-numbered byte with bit 7 set, shifted left by 22. It is 0 when no byte is valid, and it holds its value until the next run completes.
- R8: A `start_i` pulse while busy is ignored: the walk continues with the sizes and codes latched at the original start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Starts a walk when idle |
| size_i | input | 32 | Raw bank sizes in 4 MiB units, byte N for bank N |
| cfg_i | input | 16 | Geometry codes, nibble N for bank N |
| end_addr_o | output | 32 | Ending-address word, byte N for bank N, bit 7 = valid |
| cfg_word_o | output | 16 | Packed configuration word |
| total_bytes_o | output | 32 | Total memory in bytes |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse when the walk completes |

## Verification
The hardest state to reach from the ports is a partly converted word, where some bytes are finished, others still hold raw sizes, and the configuration word mixes new and old nibbles. The stimulus samples the outputs one clock after the first bank is processed. At that point byte 0 and nibble 0 must be new and the rest untouched. Saturation arises only when cumulative sizes pass 0x7f, so random sizes are biased towards large bytes and towards zeros. Directed cases add an exact crossing of 0x7f, all-empty banks and a populated bank sitting above empty ones. A second start is also pulsed in mid-walk with different inputs.

// File: rtl/bea_pkg.sv
package bea_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walk_st_e;

endpackage

// File: rtl/bea_rst_sync.sv
module bea_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_q = sync_q[STAGES-1];

endmodule

// File: rtl/bea_bank_step.sv
module bea_bank_step #(
  parameter int SIZE_W = 8
) (
  input  logic [SIZE_W-1:0] size_i,
  input  logic [SIZE_W-2:0] run_i,
  output logic [SIZE_W-1:0] byte_o,
  output logic [SIZE_W-2:0] run_o
);

  localparam int SUM_W = SIZE_W + 1;

  logic [SUM_W-1:0]  sum;
  logic              empty;
  logic              sat;
  logic [SIZE_W-2:0] clipped;

  always_comb begin
    sum     = {1'b0, size_i} + {2'b00, run_i};
    empty   = (size_i == '0);
    sat     = sum[SUM_W-1] | sum[SUM_W-2];
    clipped = sat ? '1 : sum[SIZE_W-2:0];
    if (empty) begin
      byte_o = '0;
      run_o  = run_i;
    end else begin
      byte_o = {1'b1, clipped};
      run_o  = clipped;
    end
  end

  // R5
  always_comb begin
    run_mono_chk: assert (run_o >= run_i);
  end

endmodule

// File: rtl/bea_cfg_merge.sv
module bea_cfg_merge #(
  parameter int NUM_BANKS = 4,
  parameter int CFG_W     = 4,
  parameter int IDX_W     = 2
) (
  input  logic [NUM_BANKS*CFG_W-1:0] word_i,
  input  logic [NUM_BANKS*CFG_W-1:0] code_i,
  input  logic [IDX_W-1:0]           idx_i,
  output logic [NUM_BANKS*CFG_W-1:0] word_o
);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_nib
    assign word_o[g*CFG_W +: CFG_W] = (idx_i == IDX_W'(g)) ?
                                      code_i[g*CFG_W +: CFG_W] :
                                      word_i[g*CFG_W +: CFG_W];
  end

endmodule

// File: rtl/bea_top_scan.sv
module bea_top_scan #(
  parameter int NUM_BANKS = 4,
  parameter int SIZE_W    = 8
) (
  input  logic [NUM_BANKS*SIZE_W-1:0] word_i,
  output logic [SIZE_W-2:0]           top_o
);

  logic [SIZE_W-2:0] pick [NUM_BANKS+1];

  assign pick[0] = '0;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_scan
    assign pick[g+1] = word_i[g*SIZE_W + SIZE_W-1] ?
                       word_i[g*SIZE_W +: SIZE_W-1] : pick[g];
  end

  assign top_o = pick[NUM_BANKS];

endmodule

// File: rtl/bank_end_accum.sv
module bank_end_accum
  import bea_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int SIZE_W     = 8,
  parameter int CFG_W      = 4,
  parameter int COUNT_W    = 32,
  parameter int UNIT_SHIFT = 22,
  parameter logic [NUM_BANKS*CFG_W-1:0] CFG_INIT = 16'hBBBB
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [NUM_BANKS*SIZE_W-1:0]   size_i,
  input  logic [NUM_BANKS*CFG_W-1:0]    cfg_i,
  output logic [NUM_BANKS*SIZE_W-1:0]   end_addr_o,
  output logic [NUM_BANKS*CFG_W-1:0]    cfg_word_o,
  output logic [COUNT_W-1:0]            total_bytes_o,
  output logic                          busy_o,
  output logic                          done_o
);

  localparam int END_W = NUM_BANKS * SIZE_W;
  localparam int CW_W  = NUM_BANKS * CFG_W;
  localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BANKS - 1);

  logic              rst_q;
  walk_st_e          st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [SIZE_W-2:0] run_q, run_d;
  logic [END_W-1:0]  end_q, end_d, end_walk;
  logic [CW_W-1:0]   code_q, code_d;
  logic [CW_W-1:0]   cfg_q, cfg_d, cfg_walk;
  logic [COUNT_W-1:0] total_q, total_d;
  logic              done_q, done_d;

  logic              load_en, walk_en, fin_en;
  logic [SIZE_W-1:0] bytes [NUM_BANKS];
  logic [SIZE_W-1:0] cur_size;
  logic [SIZE_W-1:0] step_byte;
  logic [SIZE_W-2:0] step_run;
  logic [SIZE_W-2:0] scan_top;

  bea_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bytes
    assign bytes[g] = end_q[g*SIZE_W +: SIZE_W];
    assign end_walk[g*SIZE_W +: SIZE_W] = (idx_q == IDX_W'(g)) ? step_byte : bytes[g];
  end

  assign cur_size = bytes[idx_q];

  bea_bank_step #(.SIZE_W(SIZE_W)) u_step (
    .size_i (cur_size),
    .run_i  (run_q),
    .byte_o (step_byte),
    .run_o  (step_run)
  );

  bea_cfg_merge #(.NUM_BANKS(NUM_BANKS), .CFG_W(CFG_W), .IDX_W(IDX_W)) u_cfg (
    .word_i (cfg_q),
    .code_i (code_q),
    .idx_i  (idx_q),
    .word_o (cfg_walk)
  );

  bea_top_scan #(.NUM_BANKS(NUM_BANKS), .SIZE_W(SIZE_W)) u_scan (
    .word_i (end_walk),
    .top_o  (scan_top)
  );

  assign load_en = (st_q == ST_IDLE) && start_i;
  assign walk_en = (st_q == ST_WALK);
  assign fin_en  = walk_en && (idx_q == LAST);

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    run_d   = run_q;
    end_d   = end_q;
    code_d  = code_q;
    cfg_d   = cfg_q;
    total_d = total_q;
    done_d  = 1'b0;
    if (load_en) begin
      st_d   = ST_WALK;
      idx_d  = '0;
      run_d  = '0;
      end_d  = size_i;
      code_d = cfg_i;
    end else if (walk_en) begin
      end_d = end_walk;
      run_d = step_run;
      cfg_d = cfg_walk;
      if (fin_en) begin
        st_d    = ST_IDLE;
        done_d  = 1'b1;
        total_d = COUNT_W'(scan_top) << UNIT_SHIFT;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      run_q   <= '0;
      end_q   <= '0;
      code_q  <= '0;
      cfg_q   <= CFG_INIT;
      total_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      if (load_en || walk_en) begin
        st_q  <= st_d;
        idx_q <= idx_d;
        run_q <= run_d;
        end_q <= end_d;
      end
      if (load_en) begin
        code_q <= code_d;
      end
      if (walk_en) begin
        cfg_q <= cfg_d;
      end
      if (fin_en) begin
        total_q <= total_d;
      end
    end
  end

  assign end_addr_o    = end_q;
  assign cfg_word_o    = cfg_q;
  assign total_bytes_o = total_q;
  assign busy_o        = (st_q == ST_WALK);
  assign done_o        = done_q;

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q)
    done_q |=> !done_q);

  // R2
  walk_len_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (walk_en && idx_q != LAST) |=> (st_q == ST_WALK));

  // R3
  empty_bank_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (walk_en && cur_size == '0) |=> (bytes[$past(idx_q)] == '0 && run_q == $past(run_q)));

  // R4
  valid_flag_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (walk_en && cur_size != '0) |=> bytes[$past(idx_q)][SIZE_W-1]);

  // R5
  run_grow_chk: assert property (@(posedge clk) disable iff (!rst_q)
    walk_en |=> (run_q >= $past(run_q)));

  // R6
  cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (walk_en && idx_q == '0) |=> (cfg_q[CW_W-1:CFG_W] == $past(cfg_q[CW_W-1:CFG_W])));

  // R7
  total_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !done_q |-> $stable(total_q));

  // R8
  restart_ign_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (walk_en && start_i && idx_q != LAST) |=> (idx_q == $past(idx_q) + 1'b1));

endmodule

// File: tb/sim_bank_end_accum.sv
module sim_bank_end_accum;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] size_i = '0;
  logic [15:0] cfg_i = '0;
  logic [31:0] end_addr_o;
  logic [15:0] cfg_word_o;
  logic [31:0] total_bytes_o;
  logic        busy_o;
  logic        done_o;

  int nchk  = 0;
  int nfail = 0;
  logic [15:0] cfg_model = 16'hBBBB;
  logic [31:0] total_model = '0;

  always #4 clk = ~clk;

  bank_end_accum u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .size_i        (size_i),
    .cfg_i         (cfg_i),
    .end_addr_o    (end_addr_o),
    .cfg_word_o    (cfg_word_o),
    .total_bytes_o (total_bytes_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_end(input logic [31:0] sz);
    logic [31:0] w = '0;
    int run = 0;
    for (int b = 0; b < 4; b++) begin
      int s = int'(sz[b*8 +: 8]);
      if (s != 0) begin
        int v = s + run;
        if (v > 127) v = 127;
        run = v;
        w[b*8 +: 8] = 8'(v) | 8'h80;
      end
    end
    return w;
  endfunction

  function automatic logic [31:0] ref_total(input logic [31:0] w);
    logic [31:0] t = '0;
    for (int b = 0; b < 4; b++) begin
      if (w[b*8+7]) t = {25'd0, w[b*8 +: 7]} << 22;
    end
    return t;
  endfunction

  function automatic logic [7:0] rnd_byte();
    int k = int'($urandom % 4);
    if (k == 0) return 8'h00;
    if (k == 1) return 8'(1 + $urandom % 32);
    if (k == 2) return 8'(32 + $urandom % 64);
    return 8'($urandom);
  endfunction

  task automatic run_case(input logic [31:0] sz, input logic [15:0] cf, input bit restart);
    logic [31:0] e_end = ref_end(sz);
    logic [31:0] e_tot = ref_total(e_end);
    @(negedge clk);
    size_i  = sz;
    cfg_i   = cf;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 busy after start", {31'd0, busy_o}, 32'd1);
    chk("R2 raw sizes loaded", end_addr_o, sz);
    chk("R7 total held", total_bytes_o, total_model);
    @(negedge clk);
    chk("R3 R4 bank0 done, upper raw", end_addr_o, {sz[31:8], e_end[7:0]});
    chk("R6 nibble0 only", {16'd0, cfg_word_o}, {16'd0, cfg_model[15:4], cf[3:0]});
    if (restart) begin
      size_i  = ~sz;
      cfg_i   = ~cf;
      start_i = 1'b1;
    end
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R2 done pulse", {30'd0, done_o, busy_o}, 32'd2);
    chk("R4 R5 R8 end word", end_addr_o, e_end);
    chk("R6 R8 cfg word", {16'd0, cfg_word_o}, {16'd0, cf});
    chk("R7 total", total_bytes_o, e_tot);
    @(negedge clk);
    chk("R2 done one cycle", {31'd0, done_o}, 32'd0);
    cfg_model   = cf;
    total_model = e_tot;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset end", end_addr_o, 32'd0);
    chk("R1 reset cfg", {16'd0, cfg_word_o}, 32'h0000BBBB);
    chk("R1 reset total/flags", {total_bytes_o[29:0], busy_o, done_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {end_addr_o[29:0], busy_o, done_o}, 32'd0);
    chk("R1 cfg after release", {16'd0, cfg_word_o}, 32'h0000BBBB);
    // directed corners
    run_case(32'h00000000, 16'h1234, 1'b0);  // R3 all empty, R7 zero total
    run_case(32'hFFFFFFFF, 16'hFEDC, 1'b0);  // R4 saturation everywhere
    run_case(32'h00000503, 16'h0A0B, 1'b0);  // R7 highest valid is bank1
    run_case(32'h01004040, 16'h5555, 1'b0);  // R4 crossing 0x7f, R3 gap
    run_case(32'h10003F40, 16'h9876, 1'b0);  // R5 exactly 0x7f then saturation
    run_case(32'h05000000, 16'h3333, 1'b1);  // R8 restart mid-walk
    run_case(32'h02030405, 16'hC0DE, 1'b1);  // R8 restart, R5 chaining
    for (int n = 0; n < 250; n++) begin
      logic [31:0] sz = {rnd_byte(), rnd_byte(), rnd_byte(), rnd_byte()};
      run_case(sz, 16'($urandom), ($urandom % 5) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule